// File: doc/BRIEF.md
# I2C Master FIFO and Interrupt Register Unit

This unit is the register-facing front end of a packet-mode I2C master. Software writes 32-bit words into a transmit queue and reads 32-bit words out of a receive queue through a small word-addressed register port. Each word carries four payload bytes. The bit-level serial engine sits on the other side: it pops transmit words, pushes received words and reports bus events such as a finished packet, a missing acknowledge or a lost arbitration.

Both queues are eight words deep. A control register holds programmable trigger levels and self-clearing flush bits. A status register packs the free transmit slots and the filled receive words into two nibbles. An interrupt block latches events, clears them on a write of one, combines them with two live data-request levels, and drives one registered interrupt line through a mask.

Register offsets are word addresses on `regAddr`: 0 transmit data (write), 1 receive data (read), 2 FIFO control, 3 FIFO status (read only), 4 interrupt status, 5 interrupt mask. Any other offset reads as zero.

Top module: `i2c_fifo_irq_unit`

## Requirements
- R1: After reset the mask, the latched interrupt events, the trigger levels and both queues are zero or empty. FIFO status reads 0x80, control reads 0x00, interrupt status reads 0x02 (only the live TX request), and `irqOut` is low.
- R2: Words written to offset 0 leave on `engTxData` in write order, one per `engTxPop`. `engTxValid` is high while the transmit queue holds a word. FIFO status bits 7:4 give the free transmit slots.
- R3: Words pushed by the engine are returned in push order by reads of offset 1. FIFO status bits 3:0 give the filled receive words. `regRdData` holds the read value from the cycle after `regRdEn` until the next read.
- R4: Writing 1 to control bit 1 flushes the transmit queue, and writing 1 to bit 0 flushes the receive queue. The bit reads 1 until the second clock edge after the write. At that edge the queue empties and the bit clears. A flush sets neither overflow nor underflow.
- R5: Control bits 7:5 hold the TX trigger and bits 4:2 hold the RX trigger. Interrupt status bit 1 is high while the free transmit slots are at or above the TX trigger. Bit 0 is high while the filled receive words exceed the RX trigger. Both bits are live levels, and writes to the status register do not change them.
- R6: A write to offset 0 while eight words are held drops the word and sets interrupt status bit 5.
- R7: A read of offset 1 while the receive queue is empty returns 0 and sets interrupt status bit 4.
- R8: `engEvents` bit 3 sets status bit 7 (packet done), bit 2 sets bit 6 (all packets done), bit 1 sets bit 3 (no acknowledge) and bit 0 sets bit 2 (arbitration lost).
- R9: Writing 1 to a bit of offset 4 clears latched bits 7:2. If an event sets a bit on the same edge that clears it, the set wins.
- R10: The mask at offset 5 resets to 0. `irqOut` is the OR of status AND mask, registered, so it follows a status change by one cycle.
- R11: A software transmit write and an engine pop on the same edge both take effect. Full and empty are judged on the occupancy before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| engTxPop | input | 1 | Engine takes the head transmit word |
| engTxData | output | 32 | Head transmit word |
| engTxValid | output | 1 | Transmit queue not empty |
| engRxPush | input | 1 | Engine delivers a received word |
| engRxData | input | 32 | Received word |
| engEvents | input | 4 | Bus events: packet done, all done, no acknowledge, arbitration lost |
| irqOut | output | 1 | Registered interrupt line |

## Verification
Two pairs of functions can fall on one edge. In the first, a software transmit write meets an engine pop, or an engine receive push meets a software read. In the second, a write-one-to-clear of a status bit meets a fresh event for that same bit. The bench drives both pairs on purpose: a transmit write next to a pop, and a clear of bit 7 while the packet-done event is high. A long random phase also collides flushes, pushes, pops and clears freely. Every cycle, a queue-based model that applies the before-edge occupancy rule judges the outputs.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] OFS_TXD  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] OFS_RXD  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] OFS_CTL  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] OFS_FST  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] OFS_ISTS = 3'd4;
  localparam logic [REG_ADDR_W-1:0] OFS_IMSK = 3'd5;

  // interrupt status bit positions
  localparam int INT_PKT    = 7;
  localparam int INT_ALL    = 6;
  localparam int INT_TX_OVF = 5;
  localparam int INT_RX_UNF = 4;
  localparam int INT_NACK   = 3;
  localparam int INT_ARB    = 2;
  localparam int INT_W      = 8;

  // engine event input positions
  localparam int EV_PKT  = 3;
  localparam int EV_ALL  = 2;
  localparam int EV_NACK = 1;
  localparam int EV_ARB  = 0;
  localparam int EV_W    = 4;

  // FIFO control layout
  localparam int CTL_RX_FLUSH    = 0;
  localparam int CTL_TX_FLUSH    = 1;
  localparam int CTL_RX_TRIG_LSB = 2;
  localparam int CTL_TX_TRIG_LSB = 5;
  localparam int TRIG_W          = 3;
  localparam int CTL_W           = 8;
  localparam int NIB_W           = 4;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txClear;
    logic rxPush;
    logic rxPop;
    logic rxClear;
  } fifoStrobes_t;
endpackage

// File: rtl/i2c_word_fifo.sv
module i2c_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             push,
  input  logic [WIDTH-1:0]                 pushData,
  input  logic                             pop,
  input  logic                             clear,
  output logic [WIDTH-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]       count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  assign pushOk = push && (count != CNT_W'(DEPTH));
  assign popOk  = pop && (count != '0);
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk && !clear) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: occupancy never exceeds the depth
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R4: a clear leaves the queue empty on the next cycle
  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (count == '0));
endmodule

// File: rtl/i2c_fifo_datapath.sv
module i2c_fifo_datapath
  import i2c_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fifoStrobes_t                stb,
  input  logic [DATA_W-1:0]           txWrData,
  input  logic [DATA_W-1:0]           rxWrData,
  output logic [DATA_W-1:0]           txHead,
  output logic [DATA_W-1:0]           rxHead,
  output logic [$clog2(DEPTH+1)-1:0]  txCount,
  output logic [$clog2(DEPTH+1)-1:0]  rxCount,
  output logic                        txNotEmpty
);
  i2c_word_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(stb.txPush), .pushData(txWrData),
    .pop(stb.txPop), .clear(stb.txClear),
    .head(txHead), .count(txCount)
  );

  i2c_word_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(stb.rxPush), .pushData(rxWrData),
    .pop(stb.rxPop), .clear(stb.rxClear),
    .head(rxHead), .count(rxCount)
  );

  assign txNotEmpty = (txCount != '0);
endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic                        regRdEn,
  input  logic [REG_ADDR_W-1:0]       regAddr,
  input  logic [CTL_W-1:0]            ctlWrData,
  input  logic                        engTxPop,
  input  logic                        engRxPush,
  input  logic [EV_W-1:0]             engEvents,
  input  logic [$clog2(DEPTH+1)-1:0]  txCount,
  input  logic [$clog2(DEPTH+1)-1:0]  rxCount,
  input  logic [DATA_W-1:0]           rxHead,
  output fifoStrobes_t                stb,
  output logic [DATA_W-1:0]           regRdData,
  output logic                        irqOut
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic wrTxd, rdRxd, wrCtl, wrSts, wrMsk;
  logic txFull, rxEmpty;
  logic [1:0] flushBusy, flushNow;
  logic [TRIG_W-1:0] txTrig, rxTrig;
  logic [CNT_W-1:0] txFree;
  logic txReq, rxReq;
  logic ovfEvt, unfEvt;
  logic [INT_W-1:INT_ARB] latched, setVec, clrVec;
  logic [INT_W-1:0] statusVec, intMask;
  logic [DATA_W-1:0] rdMux;

  assign wrTxd = regWrEn && (regAddr == OFS_TXD);
  assign rdRxd = regRdEn && (regAddr == OFS_RXD);
  assign wrCtl = regWrEn && (regAddr == OFS_CTL);
  assign wrSts = regWrEn && (regAddr == OFS_ISTS);
  assign wrMsk = regWrEn && (regAddr == OFS_IMSK);

  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign rxEmpty = (rxCount == '0);

  // flush sequencers: index 0 = receive, index 1 = transmit (matches control bits)
  for (genvar ch = 0; ch < 2; ch++) begin : gFlush
    logic [1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         cnt <= '0;
      else if (wrCtl && ctlWrData[ch])   cnt <= 2'd2;
      else if (cnt != '0)                cnt <= cnt - 2'd1;
    end
    assign flushBusy[ch] = (cnt != '0);
    assign flushNow[ch]  = (cnt == 2'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txTrig <= '0;
      rxTrig <= '0;
    end else if (wrCtl) begin
      txTrig <= ctlWrData[CTL_TX_TRIG_LSB +: TRIG_W];
      rxTrig <= ctlWrData[CTL_RX_TRIG_LSB +: TRIG_W];
    end
  end

  assign txFree = CNT_W'(DEPTH) - txCount;
  assign txReq  = (txFree >= CNT_W'(txTrig));
  assign rxReq  = (rxCount > CNT_W'(rxTrig));

  assign ovfEvt = wrTxd && txFull;
  assign unfEvt = rdRxd && rxEmpty;

  assign setVec = {engEvents[EV_PKT], engEvents[EV_ALL], ovfEvt, unfEvt,
                   engEvents[EV_NACK], engEvents[EV_ARB]};
  assign clrVec = wrSts ? ctlWrData[INT_W-1:INT_ARB] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latched <= '0;
    else       latched <= (latched & ~clrVec) | setVec;
  end

  assign statusVec = {latched, txReq, rxReq};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      intMask <= '0;
    else if (wrMsk) intMask <= ctlWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(statusVec & intMask);
  end

  always_comb begin
    case (regAddr)
      OFS_RXD:  rdMux = rxEmpty ? '0 : rxHead;
      OFS_CTL:  rdMux = DATA_W'({txTrig, rxTrig, flushBusy});
      OFS_FST:  rdMux = DATA_W'({NIB_W'(txFree), NIB_W'(rxCount)});
      OFS_ISTS: rdMux = DATA_W'(statusVec);
      OFS_IMSK: rdMux = DATA_W'(intMask);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end

  always_comb begin
    stb.txPush  = wrTxd && !txFull;
    stb.txPop   = engTxPop;
    stb.txClear = flushNow[CTL_TX_FLUSH];
    stb.rxPush  = engRxPush;
    stb.rxPop   = rdRxd;
    stb.rxClear = flushNow[CTL_RX_FLUSH];
  end

  // R4: the edge that ends a transmit flush leaves the queue empty
  assert_tx_flush_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    flushNow[CTL_TX_FLUSH] |=> (txCount == '0));

  // R6: a write into a full transmit queue raises overflow
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrTxd && txFull) |=> latched[INT_TX_OVF]);

  // R7: a read of an empty receive queue raises underflow
  assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdRxd && rxEmpty) |=> latched[INT_RX_UNF]);

  // R9: clearing the packet bit with no new event leaves it low
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrSts && ctlWrData[INT_PKT] && !engEvents[EV_PKT]) |=> !latched[INT_PKT]);

  // R10: with an all-zero mask the line stays low next cycle
  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intMask == '0) |=> !irqOut);
endmodule

// File: rtl/i2c_fifo_irq_unit.sv
module i2c_fifo_irq_unit
  import i2c_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  engTxPop,
  output logic [DATA_W-1:0]     engTxData,
  output logic                  engTxValid,
  input  logic                  engRxPush,
  input  logic [DATA_W-1:0]     engRxData,
  input  logic [EV_W-1:0]       engEvents,
  output logic                  irqOut
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrobes_t stb;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [DATA_W-1:0] rxHead;

  i2c_reg_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .ctlWrData(regWrData[CTL_W-1:0]),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .engEvents(engEvents),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .stb(stb), .regRdData(regRdData), .irqOut(irqOut)
  );

  i2c_fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .txWrData(regWrData), .rxWrData(engRxData),
    .txHead(engTxData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount),
    .txNotEmpty(engTxValid)
  );
endmodule

// File: tb/i2c_fifo_irq_unit_tb.sv
module i2c_fifo_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engTxPop = 1'b0;
  logic [31:0] engTxData;
  logic        engTxValid;
  logic        engRxPush = 1'b0;
  logic [31:0] engRxData = '0;
  logic [3:0]  engEvents = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [31:0] mTx[$];
  logic [31:0] mRx[$];
  logic [1:0]  mFl[2];
  logic [2:0]  mTxTrig, mRxTrig;
  logic [7:0]  mLat, mMask;
  logic        irqM;
  logic [31:0] rdM;
  logic [2:0]  lastAddr;

  i2c_fifo_irq_unit u_dut (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .engTxPop(engTxPop), .engTxData(engTxData), .engTxValid(engTxValid),
    .engRxPush(engRxPush), .engRxData(engRxData),
    .engEvents(engEvents), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic modelUpdate();
    int txc, rxc;
    logic [7:0] stat, setv, clrv;
    logic [1:0] clrNow;
    txc = mTx.size();
    rxc = mRx.size();
    stat = {mLat[7:2], ((DEPTH - txc) >= int'(mTxTrig)), (rxc > int'(mRxTrig))};
    irqM = |(stat & mMask);
    setv = '0;
    if (regRdEn) begin
      case (regAddr)
        3'd1: if (rxc > 0) rdM = mRx[0]; else begin rdM = '0; setv[4] = 1'b1; end
        3'd2: rdM = {24'b0, mTxTrig, mRxTrig, (mFl[1] != 0), (mFl[0] != 0)};
        3'd3: rdM = {24'b0, 4'(DEPTH - txc), 4'(rxc)};
        3'd4: rdM = {24'b0, stat};
        3'd5: rdM = {24'b0, mMask};
        default: rdM = '0;
      endcase
      lastAddr = regAddr;
    end
    if (regWrEn && regAddr == 3'd0 && txc == DEPTH) setv[5] = 1'b1;
    setv[7] = engEvents[3];
    setv[6] = engEvents[2];
    setv[3] = engEvents[1];
    setv[2] = engEvents[0];
    clrv = (regWrEn && regAddr == 3'd4) ? regWrData[7:0] : 8'h00;
    mLat = ((mLat & ~clrv) | setv) & 8'hFC;
    if (regWrEn && regAddr == 3'd5) mMask = regWrData[7:0];
    for (int ch = 0; ch < 2; ch++) begin
      clrNow[ch] = (mFl[ch] == 2'd1);
      if (regWrEn && regAddr == 3'd2 && regWrData[ch]) mFl[ch] = 2'd2;
      else if (mFl[ch] != 0) mFl[ch] = mFl[ch] - 2'd1;
    end
    if (regWrEn && regAddr == 3'd2) begin
      mTxTrig = regWrData[7:5];
      mRxTrig = regWrData[4:2];
    end
    if (clrNow[1]) mTx.delete();
    else begin
      if (engTxPop && txc > 0) void'(mTx.pop_front());
      if (regWrEn && regAddr == 3'd0 && txc < DEPTH) mTx.push_back(regWrData);
    end
    if (clrNow[0]) mRx.delete();
    else begin
      if (regRdEn && regAddr == 3'd1 && rxc > 0) void'(mRx.pop_front());
      if (engRxPush && rxc < DEPTH) mRx.push_back(engRxData);
    end
  endtask

  function automatic string addrTag(input logic [2:0] a);
    case (a)
      3'd1: return "R3 rx read";
      3'd2: return "R4 control read";
      3'd3: return "R2 fifo status read";
      3'd4: return "R9 int status read";
      3'd5: return "R10 mask read";
      default: return "R3 read data";
    endcase
  endfunction

  task automatic compareAll();
    chk("R2 engTxValid", 32'(engTxValid), 32'(mTx.size() > 0));
    if (mTx.size() > 0) chk("R2 engTxData", engTxData, mTx[0]);
    chk("R10 irqOut", 32'(irqOut), 32'(irqM));
    chk(addrTag(lastAddr), regRdData, rdM);
  endtask

  task automatic step();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareAll();
    regWrEn = 1'b0; regRdEn = 1'b0; engTxPop = 1'b0;
    engRxPush = 1'b0; engEvents = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
  endtask

  task automatic rd(input logic [2:0] a);
    regRdEn = 1'b1; regAddr = a;
    step();
  endtask

  task automatic rxPush(input logic [31:0] d);
    engRxPush = 1'b1; engRxData = d;
    step();
  endtask

  initial begin
    mFl[0] = '0; mFl[1] = '0;
    mTxTrig = '0; mRxTrig = '0; mLat = '0; mMask = '0;
    irqM = 1'b0; rdM = '0; lastAddr = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 irq after reset", 32'(irqOut), 32'd0);
    rd(3'd3); chk("R1 fifo status", regRdData, 32'h80);
    rd(3'd4); chk("R1 int status", regRdData, 32'h02);
    rd(3'd5); chk("R1 mask", regRdData, 32'h00);
    rd(3'd2); chk("R1 control", regRdData, 32'h00);

    // R2: transmit order and free count
    wr(3'd0, 32'hA1A1A1A1);
    wr(3'd0, 32'hA2A2A2A2);
    wr(3'd0, 32'hA3A3A3A3);
    chk("R2 head word", engTxData, 32'hA1A1A1A1);
    rd(3'd3); chk("R2 free slots", regRdData, 32'h50);

    // R11: write and pop on the same edge
    engTxPop = 1'b1;
    wr(3'd0, 32'hA4A4A4A4);
    chk("R11 head after pop", engTxData, 32'hA2A2A2A2);
    rd(3'd3); chk("R11 occupancy kept", regRdData, 32'h50);

    // R6: overflow when full
    for (int i = 0; i < 5; i++) wr(3'd0, 32'hB0000000 + 32'(i));
    wr(3'd0, 32'hCCCCCCCC);
    rd(3'd4); chk("R6 overflow bit", regRdData, 32'h22);
    rd(3'd3); chk("R6 word dropped, full", regRdData, 32'h00);
    wr(3'd4, 32'h20);
    rd(3'd4); chk("R9 overflow cleared", regRdData, 32'h02);

    // R4: transmit flush timing
    wr(3'd2, 32'h02);
    rd(3'd2); chk("R4 flush bit busy", regRdData, 32'h02);
    rd(3'd3); chk("R4 still full before clear edge", regRdData, 32'h00);
    rd(3'd3); chk("R4 emptied", regRdData, 32'h80);
    rd(3'd4); chk("R4 no overflow from flush", regRdData, 32'h02);
    rd(3'd2); chk("R4 flush bit cleared", regRdData, 32'h00);

    // R3 / R7: receive path and underflow
    rxPush(32'hD0D0D0D0);
    rxPush(32'hD1D1D1D1);
    rxPush(32'hD2D2D2D2);
    rd(3'd3); chk("R3 filled count", regRdData, 32'h83);
    rd(3'd1); chk("R3 first word", regRdData, 32'hD0D0D0D0);
    rd(3'd1); chk("R3 second word", regRdData, 32'hD1D1D1D1);
    rd(3'd1); chk("R3 third word", regRdData, 32'hD2D2D2D2);
    rd(3'd1); chk("R7 empty read value", regRdData, 32'h0);
    rd(3'd4); chk("R7 underflow bit", regRdData, 32'h12);
    wr(3'd4, 32'hFF);
    rd(3'd4); chk("R9 clear all", regRdData, 32'h02);

    // R5: trigger levels
    wr(3'd2, 32'hA4);
    rd(3'd2); chk("R5 trigger fields", regRdData, 32'hA4);
    rd(3'd4); chk("R5 tx request at free 8", regRdData, 32'h02);
    for (int i = 0; i < 4; i++) wr(3'd0, 32'hE0000000 + 32'(i));
    rd(3'd4); chk("R5 tx request off at free 4", regRdData, 32'h00);
    rxPush(32'h11111111);
    rd(3'd4); chk("R5 rx request off at 1", regRdData, 32'h00);
    rxPush(32'h22222222);
    rd(3'd4); chk("R5 rx request on at 2", regRdData, 32'h01);
    wr(3'd4, 32'h03);
    rd(3'd4); chk("R5 live bits unaffected by write", regRdData, 32'h01);

    // R8 / R10: events and the registered line
    wr(3'd5, 32'h80);
    engEvents = 4'b1000;
    step();
    chk("R10 irq one cycle late", 32'(irqOut), 32'd0);
    step();
    chk("R10 irq raised", 32'(irqOut), 32'd1);
    rd(3'd4); chk("R8 packet done bit", regRdData, 32'h81);
    engEvents = 4'b0111;
    step();
    rd(3'd4); chk("R8 other events", regRdData, 32'hCD);

    // R9: set wins over a same-edge clear
    engEvents = 4'b1000;
    wr(3'd4, 32'h80);
    rd(3'd4); chk("R9 set beats clear", regRdData, 32'hCD);
    wr(3'd4, 32'hCC);
    rd(3'd4); chk("R9 selective clear", regRdData, 32'h01);
    step();
    chk("R10 irq dropped", 32'(irqOut), 32'd0);

    // R4: receive flush
    wr(3'd2, 32'hA5);
    step(); step();
    rd(3'd3); chk("R4 rx flushed", regRdData, 32'h40);
    rd(3'd4); chk("R4 no underflow from flush", regRdData, 32'h00);

    // random collisions of every function against the model (R11)
    for (int n = 0; n < 3000; n++) begin
      regWrEn   = ($urandom_range(0, 3) == 0);
      regRdEn   = ($urandom_range(0, 2) == 0);
      regAddr   = 3'($urandom_range(0, 6));
      regWrData = $urandom();
      if (regAddr == 3'd2 && $urandom_range(0, 5) != 0) regWrData[1:0] = 2'b00;
      engTxPop  = ($urandom_range(0, 2) == 0);
      engRxPush = ($urandom_range(0, 2) == 0);
      engRxData = $urandom();
      engEvents = ($urandom_range(0, 7) == 0) ? 4'($urandom()) : 4'h0;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule